// File: doc/BRIEF.md
# Configurable serial result shifter

This block is the serial data port of a 10-bit converter front end. A host frames each transfer by pulling a chip-select low and then toggling a serial clock. During the frame the block takes in a configuration word on the data input and sends out the most recently stored conversion result on the data output. The bit order, the code format and the output word length are all set by that configuration.

The inputs are sampled by a local system clock through two-stage synchronizers, so the serial clock, the select and the data line may be asynchronous to it. The result comes in as a 10-bit offset-binary code with a one-cycle load strobe. The block can send it unchanged as straight binary, or with its top bit inverted as two's complement. The two kinds of setting take effect at different times. The bit order and the code format take effect only from the next frame. The word length, carried in the last two configuration bits, applies to the frame that is carrying it.

Top module: `serial_result_port`

## Requirements
- R1: `dout_oe` is low and `dout` is 0 whenever no frame is recognised. `dout_oe` is high from the recognised falling edge of `cs_n` until its recognised rising edge.
- R2: The first 8 data-input bits are taken on rising `sclk` edges and shifted into the configuration word. The first bit received ends up at `cfg[7]`. The fields are `cfg[3]` = unipolar (UNI), `cfg[2]` = MSB-first (MSBF) and `cfg[1:0]` = length code (WL). Data-input bits after the eighth are ignored.
- R3: The length code read in the current frame sets that frame's output length: 00→8, 01→10, 10→12, 11→16 bits. Slots at or beyond the length are driven as 0.
- R4: When the length exceeds 10, slots 10 to 15 are driven as 0.
- R5: With MSBF=1, slot k carries word bit 9−k. With MSBF=0, slot k carries word bit k. MSBF is taken from the configuration latched before the frame started.
- R6: With UNI=1, the word sent is the stored result unchanged. With UNI=0, the word is the stored result with bit 9 inverted. UNI is taken from the configuration latched before the frame.
- R7: `cfg` is updated only at the end of a frame, and only if at least 8 rising `sclk` edges were seen in it. A shorter frame leaves `cfg` unchanged.
- R8: The word is captured at frame start from the last result loaded by `result_vld`. A load during a frame does not affect that frame but is sent in the next one.
- R9: After reset, `cfg` is 8'h0D (UNI=1, MSBF=1, 10 bits), the stored result is 0 and `dout_oe` is low.
- R10: Slot 0 is presented as soon as the frame is recognised. Each falling `sclk` edge advances the output by one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| result | input | 10 | Conversion result, offset binary |
| result_vld | input | 1 | Loads `result` into the holding register |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial configuration input |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for the tri-state pad |
| cfg | output | 8 | Latched configuration word |

## Verification
The hardest cases to reach combine several frames in a row. The settings that pipeline to the next frame must differ from one frame to the next. The word length must change in the same frame that carries a new bit order. Three frames are also needed that cannot be seen from a single transfer: a truncated frame with fewer than 8 clocks, a result load in the middle of a frame, and a frame carrying extra input bits. The stimulus chains frames with alternating order, format and length, then inserts each of those three frames. A behavioural model in the bench predicts every output slot from the configuration held before each frame.

// File: rtl/serial_result_port.sv
module serial_result_port #(
  parameter int RES_W   = 10,
  parameter int CFG_W   = 8,
  parameter int SYNC    = 2,
  parameter int MAX_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] result,
  input  logic             result_vld,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             din,
  output logic             dout,
  output logic             dout_oe,
  output logic [CFG_W-1:0] cfg
);
  localparam int IDX_W    = $clog2(MAX_LEN + 1);
  localparam int BCW      = $clog2(CFG_W + 1);
  localparam int SELW     = $clog2(RES_W);
  localparam int POS_UNI  = 3;
  localparam int POS_MSBF = 2;
  localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(13);

  logic [SYNC-1:0] cs_p, sc_p, di_p;
  logic cs_d, sc_d;
  logic frame_q;
  logic [RES_W-1:0] hold_q, word_q, rev_w, ord_w;
  logic [CFG_W-1:0] cfg_sh;
  logic [BCW-1:0]   nin;
  logic [IDX_W-1:0] idx, len_v;

  wire cs_s = cs_p[SYNC-1];
  wire sc_s = sc_p[SYNC-1];
  wire di_s = di_p[SYNC-1];
  wire go   = cs_d & ~cs_s;
  wire stop = ~cs_d & cs_s & frame_q;
  wire rise = frame_q & sc_s & ~sc_d;
  wire fall = frame_q & ~sc_s & sc_d;
  wire cfg_full = (nin == BCW'(CFG_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '1;
      sc_p <= '0;
      di_p <= '0;
      cs_d <= 1'b1;
      sc_d <= 1'b0;
    end else begin
      cs_p <= {cs_p[SYNC-2:0], cs_n};
      sc_p <= {sc_p[SYNC-2:0], sclk};
      di_p <= {di_p[SYNC-2:0], din};
      cs_d <= cs_s;
      sc_d <= sc_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (result_vld) hold_q <= result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      word_q  <= '0;
      cfg_sh  <= '0;
      nin     <= '0;
      idx     <= '0;
      cfg     <= CFG_RST;
    end else if (go) begin
      frame_q <= 1'b1;
      word_q  <= cfg[POS_UNI] ? hold_q : (hold_q ^ (RES_W'(1) << (RES_W - 1)));
      cfg_sh  <= '0;
      nin     <= '0;
      idx     <= '0;
    end else if (stop) begin
      frame_q <= 1'b0;
      if (cfg_full) cfg <= cfg_sh;
    end else if (frame_q) begin
      if (rise && !cfg_full) begin
        cfg_sh <= {cfg_sh[CFG_W-2:0], di_s};
        nin    <= nin + BCW'(1);
      end
      if (fall && idx < IDX_W'(MAX_LEN)) idx <= idx + IDX_W'(1);
    end
  end

  always_comb begin
    for (int i = 0; i < RES_W; i++) rev_w[i] = word_q[RES_W-1-i];
  end

  always_comb begin
    if (!cfg_full) len_v = IDX_W'(MAX_LEN);
    else begin
      case (cfg_sh[1:0])
        2'b00:   len_v = IDX_W'(8);
        2'b01:   len_v = IDX_W'(10);
        2'b10:   len_v = IDX_W'(12);
        default: len_v = IDX_W'(16);
      endcase
    end
  end

  assign ord_w   = cfg[POS_MSBF] ? rev_w : word_q;
  assign dout_oe = frame_q;
  assign dout    = frame_q && (idx < len_v) && (idx < IDX_W'(RES_W)) && ord_w[idx[SELW-1:0]];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !dout_oe |-> !dout); // R1
  AST_START_OE: assert property (@(posedge clk) disable iff (!rst_n) go |=> dout_oe); // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (frame_q && $past(frame_q)) |-> $stable(cfg)); // R7
  AST_BITS_CAP: assert property (@(posedge clk) disable iff (!rst_n) nin <= BCW'(CFG_W)); // R2
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (idx >= IDX_W'(RES_W)) |-> !dout); // R4
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n) (frame_q && $past(frame_q)) |-> $stable(word_q)); // R8
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (frame_q && $past(frame_q)) |-> (idx - $past(idx)) <= IDX_W'(1)); // R10
endmodule

// File: tb/serial_result_port_tb.sv
module serial_result_port_tb;
  localparam int H = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] result = '0;
  logic result_vld = 1'b0, sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic dout, dout_oe;
  logic [7:0] cfg;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m_cfg;
  logic [9:0] m_hold;

  always #5 clk = ~clk;

  serial_result_port u_dut (
    .clk(clk), .rst_n(rst_n), .result(result), .result_vld(result_vld),
    .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout), .dout_oe(dout_oe), .cfg(cfg)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [9:0] v);
    @(negedge clk);
    result = v;
    result_vld = 1'b1;
    @(negedge clk);
    result_vld = 1'b0;
    m_hold = v;
  endtask

  function automatic logic exp_bit(input logic [9:0] w, input logic msbf, input int len, input int k);
    if (k >= len || k >= 10) return 1'b0;
    return msbf ? w[9-k] : w[k];
  endfunction

  task automatic frame(input logic [7:0] word, input int n, input bit mid_load, input logic [9:0] mid_val);
    logic [9:0] w;
    logic msbf;
    int len;
    w = m_cfg[3] ? m_hold : (m_hold ^ 10'h200);
    msbf = m_cfg[2];
    len = 16;
    if (n >= 8) len = (word[1:0] == 2'b00) ? 8 : (word[1:0] == 2'b01) ? 10 : (word[1:0] == 2'b10) ? 12 : 16;
    @(negedge clk);
    cs_n = 1'b0;
    waitn(H);
    chk("R1 oe in frame", {15'd0, dout_oe}, 16'd1);
    chk("R10,R5,R6 slot0", {15'd0, dout}, {15'd0, exp_bit(w, msbf, len, 0)});
    for (int i = 0; i < n; i++) begin
      din = (i < 8) ? word[7-i] : 1'b1;
      sclk = 1'b1;
      waitn(H);
      if (mid_load && i == 3) load(mid_val);
      sclk = 1'b0;
      waitn(H);
      if (i + 1 < n)
        chk((i + 1 >= len) ? "R3 slot" : (i + 1 >= 10) ? "R4 slot" : "R5,R6,R8,R10 slot",
            {15'd0, dout}, {15'd0, exp_bit(w, msbf, len, i + 1)});
    end
    cs_n = 1'b1;
    din = 1'b0;
    waitn(2 * H);
    if (n >= 8) m_cfg = word;
    chk("R1 oe idle", {15'd0, dout_oe}, 16'd0);
    chk("R1 dout idle", {15'd0, dout}, 16'd0);
    chk("R2,R7 cfg", {8'd0, cfg}, {8'd0, m_cfg});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_cfg = 8'h0D;
    m_hold = '0;
    waitn(3);
    chk("R9 cfg reset", {8'd0, cfg}, 16'h000D);
    chk("R9 oe reset", {15'd0, dout_oe}, 16'd0);
    rst_n = 1'b1;
    waitn(3);
    frame(8'b0000_1001, 10, 1'b0, '0);
    load(10'h2A5);
    frame(8'b0000_0010, 12, 1'b0, '0);
    frame(8'b0000_0111, 16, 1'b1, 10'h133);
    frame(8'b1110_1100, 8, 1'b0, '0);
    frame(8'hF0, 4, 1'b0, '0);
    load(10'h0C1);
    frame(8'b0000_0001, 10, 1'b0, '0);
    frame(8'b1010_0011, 16, 1'b0, '0);
    load(10'h3FF);
    frame(8'b0000_1100, 8, 1'b0, '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule